// File: doc/BRIEF.md
# Interrupt Cause Register Bank

This block gathers single-cycle hardware event pulses into a sticky cause register and turns them into one level interrupt line. A mask register decides which cause bits may reach that line. Software changes the mask only through two write-only addresses: one sets mask bits and the other clears them. Because of this, a read-modify-write of the mask is never needed. A per-bit clear-mode register decides how each cause bit is removed. A bit in mode 1 clears when the cause word is read. A bit in mode 0 clears when software writes a 1 to it at the cause address.

The bus side is a plain word port with one write strobe and one read strobe. Read data is registered and appears the cycle after the strobe. A handler typically first reads the masked view, then masks the sources it is about to serve. It reads the cause word; clear-on-read bits are removed by that read. It writes the same word back to remove the write-1-to-clear bits, and finally clears the mask bits again. A cause word that reads as zero carries no interrupt.

Top module: `intr_cause_bank`

## Requirements
- R1: After reset the cause register reads 0 and the clear-mode register reads 0. The mask value reads all ones, and `irq_o` is 0.
- R2: A 1 on `evt_i[n]` for one clock sets cause bit n. The bit stays set until it is cleared as R3 or R4 describe.
- R3: A bit whose clear-mode bit is 0 clears when a word with that bit at 1 is written to address 0 (cause). In this mode, reading address 0 leaves the cause unchanged.
- R4: A bit whose clear-mode bit is 1 clears on a read of address 0, and that read returns the bit as 1. A write to address 0 has no effect on such a bit.
- R5: Address 1 is the clear-mode register. It can be read and written, and each bit selects its own mode independently of the others.
- R6: A write to address 2 sets each mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R7: A write to address 3 clears each mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R8: Reading address 4 returns cause AND NOT mask. This read changes neither the cause nor the mask.
- R9: Reading address 5 returns the current mask.
- R10: `irq_o` is a register. It goes to 1 one cycle after (cause AND NOT mask) becomes nonzero, and back to 0 one cycle after it becomes zero.
- R11: If an event and a clear of the same bit fall in the same cycle, the bit ends up set. The clear may be a write-1 or a clear-on-read.
- R12: `rdata_o` holds the value of the register read, valid the cycle after `rd_en_i`. Addresses 6 and 7 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | SRC_W | Event pulses, one per cause bit |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 3 | Word address of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Interrupt, high while any unmasked cause bit is set |

## Verification
The assertions assume that `evt_i`, the strobes, the address and the write data are stable around the rising edge. They also assume that these inputs are held low during reset, because several properties compare against the previous cycle. The clear properties assume that no event arrives in the same cycle, so they are guarded with `evt_i == 0`. The bench drives every input on the falling edge and keeps everything low during reset. It raises an event together with a clear only in the set-wins scenario, and that case is covered by its own property.

// File: rtl/icb_pkg.sv
package icb_pkg;
   localparam int unsigned ICB_ADDR_W = 3;

   typedef enum logic [ICB_ADDR_W-1:0] {
      ICB_CAUSE = 3'd0,
      ICB_MODE  = 3'd1,
      ICB_MSET  = 3'd2,
      ICB_MCLR  = 3'd3,
      ICB_MVIEW = 3'd4,
      ICB_MVAL  = 3'd5
   } icb_reg_e;
endpackage

// File: rtl/icb_cause_store.sv
module icb_cause_store #(
   parameter int unsigned SRC_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [SRC_W-1:0] evt_i,
   input  logic             w1c_wr_i,
   input  logic             cause_rd_i,
   input  logic [SRC_W-1:0] wbits_i,
   input  logic [SRC_W-1:0] mode_i,
   output logic [SRC_W-1:0] cause_o
);
   logic [SRC_W-1:0] cause_q;

   // one cell per source; event takes priority over any clear
   for (genvar b = 0; b < SRC_W; b++) begin : g_bit
      logic clr_b;
      always_comb begin
         clr_b = (w1c_wr_i & wbits_i[b] & ~mode_i[b]) | (cause_rd_i & mode_i[b]);
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) cause_q[b] <= 1'b0;
         else         cause_q[b] <= (cause_q[b] & ~clr_b) | evt_i[b];
      end
   end

   assign cause_o = cause_q;
endmodule

// File: rtl/icb_ctrl_regs.sv
module icb_ctrl_regs #(
   parameter int unsigned SRC_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             mset_wr_i,
   input  logic             mclr_wr_i,
   input  logic             mode_wr_i,
   input  logic [SRC_W-1:0] wbits_i,
   output logic [SRC_W-1:0] mask_o,
   output logic [SRC_W-1:0] mode_o
);
   logic [SRC_W-1:0] mask_q;
   logic [SRC_W-1:0] mode_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mask_q <= '1;
      end else if (mset_wr_i) begin
         mask_q <= mask_q | wbits_i;
      end else if (mclr_wr_i) begin
         mask_q <= mask_q & ~wbits_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        mode_q <= '0;
      else if (mode_wr_i) mode_q <= wbits_i;
   end

   assign mask_o = mask_q;
   assign mode_o = mode_q;
endmodule

// File: rtl/icb_out_stage.sv
module icb_out_stage
   import icb_pkg::*;
#(
   parameter int unsigned SRC_W  = 32,
   parameter int unsigned DATA_W = 32
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  rd_en_i,
   input  logic [ICB_ADDR_W-1:0] addr_i,
   input  logic [SRC_W-1:0]      cause_i,
   input  logic [SRC_W-1:0]      mask_i,
   input  logic [SRC_W-1:0]      mode_i,
   output logic [DATA_W-1:0]     rdata_o,
   output logic                  irq_o
);
   localparam int unsigned PAD_W = DATA_W - SRC_W;

   logic [SRC_W-1:0]  pending;
   logic [SRC_W-1:0]  sel;
   logic [DATA_W-1:0] sel_ext;
   logic [DATA_W-1:0] rdata_q;
   logic              irq_q;

   assign pending = cause_i & ~mask_i;

   always_comb begin
      unique case (icb_reg_e'(addr_i))
         ICB_CAUSE: sel = cause_i;
         ICB_MODE:  sel = mode_i;
         ICB_MVIEW: sel = pending;
         ICB_MVAL:  sel = mask_i;
         default:   sel = '0;
      endcase
   end

   if (PAD_W == 0) begin : g_full
      assign sel_ext = sel;
   end else begin : g_pad
      assign sel_ext = {{PAD_W{1'b0}}, sel};
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      rdata_q <= '0;
      else if (rd_en_i) rdata_q <= sel_ext;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q <= 1'b0;
      else         irq_q <= |pending;
   end

   assign rdata_o = rdata_q;
   assign irq_o   = irq_q;
endmodule

// File: rtl/intr_cause_bank.sv
module intr_cause_bank
   import icb_pkg::*;
#(
   parameter int unsigned SRC_W  = 32,
   parameter int unsigned DATA_W = 32
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [SRC_W-1:0]      evt_i,
   input  logic                  wr_en_i,
   input  logic                  rd_en_i,
   input  logic [ICB_ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0]     wdata_i,
   output logic [DATA_W-1:0]     rdata_o,
   output logic                  irq_o
);
   if (SRC_W < 1 || SRC_W > DATA_W) begin : g_bad_src
      $error("intr_cause_bank: SRC_W must be in 1..DATA_W");
   end
   if (DATA_W > 64) begin : g_bad_data
      $error("intr_cause_bank: DATA_W above 64 is not supported");
   end

   logic [SRC_W-1:0] wbits;
   logic [SRC_W-1:0] cause_q;
   logic [SRC_W-1:0] mask_q;
   logic [SRC_W-1:0] mode_q;
   logic             hit_cause_wr;
   logic             hit_cause_rd;
   logic             hit_mode_wr;
   logic             hit_mset_wr;
   logic             hit_mclr_wr;

   assign wbits        = wdata_i[SRC_W-1:0];
   assign hit_cause_wr = wr_en_i && (addr_i == ICB_CAUSE);
   assign hit_cause_rd = rd_en_i && (addr_i == ICB_CAUSE);
   assign hit_mode_wr  = wr_en_i && (addr_i == ICB_MODE);
   assign hit_mset_wr  = wr_en_i && (addr_i == ICB_MSET);
   assign hit_mclr_wr  = wr_en_i && (addr_i == ICB_MCLR);

   icb_cause_store #(.SRC_W(SRC_W)) u_cause (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt_i),
      .w1c_wr_i   (hit_cause_wr),
      .cause_rd_i (hit_cause_rd),
      .wbits_i    (wbits),
      .mode_i     (mode_q),
      .cause_o    (cause_q)
   );

   icb_ctrl_regs #(.SRC_W(SRC_W)) u_ctrl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mset_wr_i (hit_mset_wr),
      .mclr_wr_i (hit_mclr_wr),
      .mode_wr_i (hit_mode_wr),
      .wbits_i   (wbits),
      .mask_o    (mask_q),
      .mode_o    (mode_q)
   );

   icb_out_stage #(.SRC_W(SRC_W), .DATA_W(DATA_W)) u_out (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .rd_en_i (rd_en_i),
      .addr_i  (addr_i),
      .cause_i (cause_q),
      .mask_i  (mask_q),
      .mode_i  (mode_q),
      .rdata_o (rdata_o),
      .irq_o   (irq_o)
   );
endmodule

// File: rtl/intr_cause_bank_chk.sv
module intr_cause_bank_chk #(
   parameter int unsigned SRC_W  = 32,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [SRC_W-1:0]  evt_i,
   input logic              wr_en_i,
   input logic              rd_en_i,
   input logic [2:0]        addr_i,
   input logic [DATA_W-1:0] wdata_i,
   input logic [SRC_W-1:0]  cause_i,
   input logic [SRC_W-1:0]  mask_i,
   input logic [SRC_W-1:0]  mode_i,
   input logic              irq_i
);
   logic [SRC_W-1:0] wb;
   assign wb = wdata_i[SRC_W-1:0];

   p_evt_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|evt_i) |=> ((cause_i & $past(evt_i)) == $past(evt_i)));

   p_w1c_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == 3'd0 && evt_i == '0)
         |=> ((cause_i & $past(wb & ~mode_i)) == '0));

   p_cor_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && addr_i == 3'd0 && evt_i == '0)
         |=> ((cause_i & $past(mode_i)) == '0));

   p_mask_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == 3'd2) |=> ((mask_i & $past(wb)) == $past(wb)));

   p_mask_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == 3'd3) |=> ((mask_i & $past(wb)) == '0));

   p_irq_raise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((cause_i & ~mask_i) != '0) |=> irq_i);

   p_irq_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((cause_i & ~mask_i) == '0) |=> !irq_i);
endmodule

bind intr_cause_bank intr_cause_bank_chk #(.SRC_W(SRC_W), .DATA_W(DATA_W)) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .evt_i   (evt_i),
   .wr_en_i (wr_en_i),
   .rd_en_i (rd_en_i),
   .addr_i  (addr_i),
   .wdata_i (wdata_i),
   .cause_i (cause_q),
   .mask_i  (mask_q),
   .mode_i  (mode_q),
   .irq_i   (irq_o)
);

// File: tb/intr_cause_bank_bench.sv
module intr_cause_bank_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] evt = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   int          n_chk = 0;
   int          n_err = 0;

   always #10 clk = ~clk;

   intr_cause_bank u_intr_cause_bank (
      .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .wr_en_i(wr_en), .rd_en_i(rd_en),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0; wdata = '0;
   endtask

   task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk); rd_en = 1'b1; addr = a;
      @(negedge clk); rd_en = 1'b0; d = rdata;
   endtask

   task automatic pulse(input logic [31:0] e);
      @(negedge clk); evt = e;
      @(negedge clk); evt = '0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 irq", {31'b0, irq}, 32'h0);
      reg_rd(3'd0, d); chk("R1 cause", d, 32'h0);
      reg_rd(3'd1, d); chk("R1 mode", d, 32'h0);
      reg_rd(3'd5, d); chk("R1 R9 mask", d, 32'hFFFF_FFFF);
   endtask

   task automatic t_latch();
      logic [31:0] d;
      pulse(32'h0000_0005);
      reg_rd(3'd0, d); chk("R2 cause latched", d, 32'h5);
      reg_rd(3'd0, d); chk("R3 read keeps w1c bits", d, 32'h5);
      chk("R10 masked no irq", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_mask();
      logic [31:0] d;
      reg_wr(3'd3, 32'h0000_0001);
      reg_rd(3'd5, d); chk("R7 mask clr", d, 32'hFFFF_FFFE);
      chk("R10 irq raised", {31'b0, irq}, 32'h1);
      reg_rd(3'd4, d); chk("R8 masked view", d, 32'h1);
      reg_rd(3'd0, d); chk("R8 view no side effect", d, 32'h5);
      reg_wr(3'd2, 32'h0000_0001);
      reg_rd(3'd5, d); chk("R6 mask set", d, 32'hFFFF_FFFF);
      chk("R10 irq dropped", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_w1c();
      logic [31:0] d;
      reg_wr(3'd0, 32'h0000_0004);
      reg_rd(3'd0, d); chk("R3 w1c one bit", d, 32'h1);
      reg_wr(3'd0, 32'h0000_0001);
      reg_rd(3'd0, d); chk("R3 w1c last bit", d, 32'h0);
   endtask

   task automatic t_cor();
      logic [31:0] d;
      reg_wr(3'd1, 32'h0000_00F0);
      reg_rd(3'd1, d); chk("R5 mode readback", d, 32'hF0);
      pulse(32'h0000_0031);
      reg_wr(3'd0, 32'h0000_0030);
      reg_rd(3'd0, d); chk("R4 write ignored by cor bits", d, 32'h31);
      reg_rd(3'd0, d); chk("R4 R5 cor cleared, w1c kept", d, 32'h01);
      reg_wr(3'd0, 32'h0000_0001);
      reg_rd(3'd0, d); chk("R3 cleanup", d, 32'h0);
   endtask

   task automatic t_set_wins();
      logic [31:0] d;
      pulse(32'h0000_0001);
      @(negedge clk); evt = 32'h1; wr_en = 1'b1; addr = 3'd0; wdata = 32'h1;
      @(negedge clk); evt = '0; wr_en = 1'b0; wdata = '0;
      reg_rd(3'd0, d); chk("R11 event beats w1c", d, 32'h1);
      @(negedge clk); evt = 32'h10; rd_en = 1'b1; addr = 3'd0;
      @(negedge clk); evt = '0; rd_en = 1'b0; d = rdata;
      chk("R11 cor read value", d, 32'h01);
      reg_rd(3'd0, d); chk("R11 event beats cor", d, 32'h11);
      reg_rd(3'd0, d); chk("R4 cor after set", d, 32'h01);
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      reg_wr(3'd6, 32'hFFFF_FFFF);
      reg_wr(3'd7, 32'h0000_0000);
      reg_rd(3'd6, d); chk("R12 unmapped reads zero", d, 32'h0);
      reg_rd(3'd5, d); chk("R12 mask untouched", d, 32'hFFFF_FFFF);
      reg_rd(3'd1, d); chk("R12 mode untouched", d, 32'hF0);
      reg_rd(3'd0, d); chk("R12 cause untouched", d, 32'h01);
      @(negedge clk); rd_en = 1'b1; addr = 3'd1;
      chk("R12 data not early", rdata, 32'h01);
      @(negedge clk); rd_en = 1'b0;
      chk("R12 data next cycle", rdata, 32'hF0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_latch();
      t_mask();
      t_w1c();
      t_cor();
      t_set_wins();
      t_unmapped();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_err++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule